// File: doc/BRIEF.md
# LIN slave header detector

This block is the receive-side controller of a LIN slave. It sits behind a byte UART receiver and watches each received character, its data byte and its framing-error indication. It picks out the break character, follows the synch field that comes after it, and treats the next character as the protected identifier. From that sequence it drives a data register, a data-ready flag, a header-detected flag, a framing-error flag, an identifier parity-error flag and a header interrupt request.

Configuration inputs select how the block behaves. One input sets when the header flag rises: on the break, or once the identifier has arrived. Another makes the synch field disappear when the baud rate is being resynchronised elsewhere. A parity-check enable turns on the identifier parity check, and a mute input lets only headers reach the data register. Every flag stays set until its own one-cycle clear strobe. Software typically runs the block in mute mode with identifier timing. It then sees one data-ready event per header, carrying the identifier, and nothing from frames it does not care about.

Top module: `lin_hdr_rx`

## Requirements
- R1: After reset, rx_dr is 0x00 and rdy, hdr, ferr, perr and irq are all 0.
- R2: A break is a character strobe with rx_ferr=1 and rx_data=0x00 while cfg_slave=1. With cfg_id_mode=0, a break sets rx_dr=0x00, rdy=1 and hdr=1 one cycle after the strobe.
- R3: With cfg_id_mode=1, the break and the synch field do not touch rx_dr, rdy or hdr. The identifier, which is the third character counting the break as the first, sets rx_dr to the identifier byte, rdy=1 and hdr=1.
- R4: With cfg_id_mode=0 and cfg_auto_sync=1, the synch field (the second character) leaves rx_dr and rdy unchanged.
- R5: With cfg_id_mode=0, cfg_auto_sync=0 and cfg_mute=0, the synch field is loaded into rx_dr and sets rdy.
- R6: When cfg_slave=1 and cfg_par_en=1, the identifier is checked. The expected value of bit 6 is b0^b1^b2^b4, and the expected value of bit 7 is the inverse of b1^b3^b4^b5. Any mismatch sets perr. No other character sets perr.
- R7: With cfg_mute=1, only header events load rx_dr and set rdy: the break in mode 0, or the identifier in mode 1. Every other character leaves rx_dr and rdy unchanged.
- R8: A character strobe with rx_ferr=1 sets ferr, except a break in slave mode. With cfg_slave=0 there are no breaks, and a zero byte with a framing error is an ordinary character that sets ferr.
- R9: irq is 1 exactly while hdr=1 and cfg_hdr_ie=1.
- R10: rdy, hdr, ferr and perr stay set until their clear strobe (clr_rdy, clr_hdr, clr_ferr, clr_perr) is 1 for a cycle. If a set and a clear of the same flag fall in the same cycle, the flag is set.
- R11: A break at any point restarts the header sequence, so the next character is taken as the synch field.
- R12: Characters outside a header, including the identifier in mode 0, are loaded into rx_dr and set rdy when cfg_mute=0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| rx_valid | input | 1 | One-cycle strobe: a received character is present |
| rx_data | input | DW (8) | Received character byte |
| rx_ferr | input | 1 | Framing error for the current character |
| cfg_slave | input | 1 | LIN slave mode enable |
| cfg_id_mode | input | 1 | Header flag timing: 0 on break, 1 after identifier |
| cfg_auto_sync | input | 1 | Synch field is swallowed (resynchronisation active) |
| cfg_par_en | input | 1 | Identifier parity check enable |
| cfg_mute | input | 1 | Pass headers only |
| cfg_hdr_ie | input | 1 | Header interrupt enable |
| clr_rdy | input | 1 | Clear strobe for rdy |
| clr_hdr | input | 1 | Clear strobe for hdr |
| clr_ferr | input | 1 | Clear strobe for ferr |
| clr_perr | input | 1 | Clear strobe for perr |
| rx_dr | output | DW (8) | Data register |
| rdy | output | 1 | Data-ready flag |
| hdr | output | 1 | Header-detected flag |
| ferr | output | 1 | Framing-error flag |
| perr | output | 1 | Identifier parity-error flag |
| irq | output | 1 | Header interrupt request |

## Verification
The data register and all four flags are registered, so each of them reflects a character strobe or clear strobe one clock edge after the edge that samples it. irq follows hdr in that same cycle and follows cfg_hdr_ie with no delay. The bench changes inputs just after a rising edge. A behavioural model updates on the same rising edge the design samples, and every output is compared with the model at the following falling edge. Directed checks after each stimulus are read just after the next rising edge, once the one-cycle latency has elapsed.

// File: rtl/lin_hdr_pkg.sv
package lin_hdr_pkg;
  typedef enum logic [1:0] {
    POS_DATA = 2'd0,
    POS_SYNC = 2'd1,
    POS_ID   = 2'd2
  } pos_e;

  localparam int FLAG_RDY  = 0;
  localparam int FLAG_HDR  = 1;
  localparam int FLAG_FERR = 2;
  localparam int FLAG_PERR = 3;
  localparam int NUM_FLAGS = 4;
endpackage

// File: rtl/lin_hdr_seq.sv
module lin_hdr_seq
  import lin_hdr_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic slave,
  input  logic brk,
  input  logic chr,
  output logic at_sync,
  output logic at_id
);
  pos_e pos_q, pos_n;

  always_comb begin
    pos_n = pos_q;
    if (!slave) begin
      pos_n = POS_DATA;
    end else if (brk) begin
      pos_n = POS_SYNC;
    end else if (chr) begin
      case (pos_q)
        POS_SYNC: pos_n = POS_ID;
        default:  pos_n = POS_DATA;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pos_q <= POS_DATA;
    else        pos_q <= pos_n;
  end

  assign at_sync = (pos_q == POS_SYNC);
  assign at_id   = (pos_q == POS_ID);

  AST_BREAK_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
    (slave && brk) |=> (at_sync && !at_id)); // R11
  AST_ID_AFTER_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
    (slave && chr && !brk && at_sync) |=> at_id); // R3
endmodule

// File: rtl/lin_id_parity.sv
module lin_id_parity #(
  parameter int DW = 8
) (
  input  logic [DW-1:0] pid,
  output logic          mismatch
);
  logic exp_p0, exp_p1;

  always_comb begin
    exp_p0   = pid[0] ^ pid[1] ^ pid[2] ^ pid[4];
    exp_p1   = ~(pid[1] ^ pid[3] ^ pid[4] ^ pid[5]);
    mismatch = (pid[6] != exp_p0) || (pid[7] != exp_p1);
  end
endmodule

// File: rtl/lin_hdr_flags.sv
module lin_hdr_flags #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set,
  input  logic [N-1:0] clr,
  output logic [N-1:0] q
);
  for (genvar i = 0; i < N; i++) begin : g_flag
    logic f_q, f_n;

    always_comb begin
      f_n = f_q;
      if (clr[i]) f_n = 1'b0;
      if (set[i]) f_n = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) f_q <= 1'b0;
      else        f_q <= f_n;
    end

    assign q[i] = f_q;

    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      set[i] |=> q[i]); // R10
    AST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (q[i] && !clr[i]) |=> q[i]); // R10
  end
endmodule

// File: rtl/lin_hdr_rx.sv
module lin_hdr_rx
  import lin_hdr_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rx_valid,
  input  logic [DW-1:0] rx_data,
  input  logic          rx_ferr,
  input  logic          cfg_slave,
  input  logic          cfg_id_mode,
  input  logic          cfg_auto_sync,
  input  logic          cfg_par_en,
  input  logic          cfg_mute,
  input  logic          cfg_hdr_ie,
  input  logic          clr_rdy,
  input  logic          clr_hdr,
  input  logic          clr_ferr,
  input  logic          clr_perr,
  output logic [DW-1:0] rx_dr,
  output logic          rdy,
  output logic          hdr,
  output logic          ferr,
  output logic          perr,
  output logic          irq
);
  // reset: asserted asynchronously, released after two clock edges
  logic [1:0] rst_sync_q;
  logic       rst_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_q = rst_sync_q[1];

  // character classification
  logic is_brk, chr, at_sync, at_id;
  logic ch_sync, ch_id, ch_norm;
  logic par_bad, hdr_set, ld;

  assign is_brk = rx_valid && cfg_slave && rx_ferr && (rx_data == '0);
  assign chr    = rx_valid && !is_brk;

  lin_hdr_seq u_seq (
    .clk     (clk),
    .rst_n   (rst_q),
    .slave   (cfg_slave),
    .brk     (is_brk),
    .chr     (chr),
    .at_sync (at_sync),
    .at_id   (at_id)
  );

  lin_id_parity #(.DW(DW)) u_par (
    .pid      (rx_data),
    .mismatch (par_bad)
  );

  always_comb begin
    ch_sync = chr && cfg_slave && at_sync;
    ch_id   = chr && cfg_slave && at_id;
    ch_norm = chr && !ch_sync && !ch_id;
    hdr_set = (is_brk && !cfg_id_mode) || (ch_id && cfg_id_mode);
    ld      = hdr_set ||
              (!cfg_mute && ((ch_sync && !cfg_id_mode && !cfg_auto_sync) ||
                             (ch_id && !cfg_id_mode) ||
                             ch_norm));
  end

  // data register
  logic [DW-1:0] dr_q, dr_n;

  always_comb begin
    dr_n = dr_q;
    if (ld) dr_n = rx_data;
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) dr_q <= '0;
    else        dr_q <= dr_n;
  end

  // sticky flags
  logic [NUM_FLAGS-1:0] fl_set, fl_clr, fl_q;

  always_comb begin
    fl_set            = '0;
    fl_clr            = '0;
    fl_set[FLAG_RDY]  = ld;
    fl_set[FLAG_HDR]  = hdr_set;
    fl_set[FLAG_FERR] = rx_valid && rx_ferr && !is_brk;
    fl_set[FLAG_PERR] = ch_id && cfg_par_en && par_bad;
    fl_clr[FLAG_RDY]  = clr_rdy;
    fl_clr[FLAG_HDR]  = clr_hdr;
    fl_clr[FLAG_FERR] = clr_ferr;
    fl_clr[FLAG_PERR] = clr_perr;
  end

  lin_hdr_flags #(.N(NUM_FLAGS)) u_flags (
    .clk   (clk),
    .rst_n (rst_q),
    .set   (fl_set),
    .clr   (fl_clr),
    .q     (fl_q)
  );

  assign rx_dr = dr_q;
  assign rdy   = fl_q[FLAG_RDY];
  assign hdr   = fl_q[FLAG_HDR];
  assign ferr  = fl_q[FLAG_FERR];
  assign perr  = fl_q[FLAG_PERR];
  assign irq   = hdr && cfg_hdr_ie;

  AST_HDR_AFTER_CHAR: assert property (@(posedge clk) disable iff (!rst_q)
    $rose(hdr) |-> $past(rx_valid)); // R2
  AST_AUTO_SYNC_SKIP: assert property (@(posedge clk) disable iff (!rst_q)
    (rx_valid && cfg_slave && at_sync && !rx_ferr && cfg_auto_sync && !cfg_id_mode) |=> $stable(rx_dr)); // R4
  AST_PERR_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_q)
    $rose(perr) |-> $past(cfg_par_en && cfg_slave)); // R6
  AST_MUTE_HOLDS_DR: assert property (@(posedge clk) disable iff (!rst_q)
    (rx_valid && cfg_mute && !at_id && !rx_ferr) |=> $stable(rx_dr)); // R7
  AST_BREAK_NO_FERR: assert property (@(posedge clk) disable iff (!rst_q)
    (rx_valid && cfg_slave && rx_ferr && (rx_data == '0) && !ferr) |=> !ferr); // R8
endmodule

// File: tb/lin_hdr_rx_tb.sv
module lin_hdr_rx_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rx_valid = 1'b0, rx_ferr = 1'b0;
  logic [7:0] rx_data = 8'h00;
  logic cfg_slave = 1'b0, cfg_id_mode = 1'b0, cfg_auto_sync = 1'b0;
  logic cfg_par_en = 1'b0, cfg_mute = 1'b0, cfg_hdr_ie = 1'b0;
  logic clr_rdy = 1'b0, clr_hdr = 1'b0, clr_ferr = 1'b0, clr_perr = 1'b0;
  logic [7:0] rx_dr;
  logic rdy, hdr, ferr, perr, irq;

  lin_hdr_rx u_dut (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_data(rx_data), .rx_ferr(rx_ferr),
    .cfg_slave(cfg_slave), .cfg_id_mode(cfg_id_mode), .cfg_auto_sync(cfg_auto_sync),
    .cfg_par_en(cfg_par_en), .cfg_mute(cfg_mute), .cfg_hdr_ie(cfg_hdr_ie),
    .clr_rdy(clr_rdy), .clr_hdr(clr_hdr), .clr_ferr(clr_ferr), .clr_perr(clr_perr),
    .rx_dr(rx_dr), .rdy(rdy), .hdr(hdr), .ferr(ferr), .perr(perr), .irq(irq)
  );

  always #2 clk = ~clk;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  string cur_req = "R1";

  task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // behavioural reference model
  logic [7:0] m_dr;
  logic m_rdy, m_hdr, m_ferr, m_perr;
  int m_cnt;

  function automatic logic pid_bad(logic [7:0] d);
    logic p0, p1;
    p0 = d[0] ^ d[1] ^ d[2] ^ d[4];
    p1 = ~(d[1] ^ d[3] ^ d[4] ^ d[5]);
    return (d[6] != p0) || (d[7] != p1);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_dr = 8'h00; m_rdy = 0; m_hdr = 0; m_ferr = 0; m_perr = 0; m_cnt = 0;
    end else begin
      logic brk, load, hset;
      load = 0; hset = 0;
      brk = rx_valid && cfg_slave && rx_ferr && rx_data == 8'h00;
      if (clr_rdy)  m_rdy = 0;
      if (clr_hdr)  m_hdr = 0;
      if (clr_ferr) m_ferr = 0;
      if (clr_perr) m_perr = 0;
      if (rx_valid) begin
        if (brk) begin
          m_cnt = 1;
          if (!cfg_id_mode) begin load = 1; hset = 1; end
        end else if (cfg_slave && m_cnt == 1) begin
          m_cnt = 2;
          if (!cfg_id_mode && !cfg_auto_sync && !cfg_mute) load = 1;
        end else if (cfg_slave && m_cnt == 2) begin
          m_cnt = 0;
          if (cfg_par_en && pid_bad(rx_data)) m_perr = 1;
          if (cfg_id_mode) begin load = 1; hset = 1; end
          else if (!cfg_mute) load = 1;
        end else begin
          m_cnt = 0;
          if (!cfg_mute) load = 1;
        end
        if (rx_ferr && !brk) m_ferr = 1;
      end
      if (!cfg_slave) m_cnt = 0;
      if (load) begin m_dr = rx_data; m_rdy = 1; end
      if (hset) m_hdr = 1;
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      check({cur_req, " model rx_dr"}, rx_dr, m_dr);
      check({cur_req, " model rdy"}, {7'd0, rdy}, {7'd0, m_rdy});
      check({cur_req, " model hdr"}, {7'd0, hdr}, {7'd0, m_hdr});
      check({cur_req, " model ferr"}, {7'd0, ferr}, {7'd0, m_ferr});
      check({cur_req, " model perr"}, {7'd0, perr}, {7'd0, m_perr});
      check({cur_req, " model irq"}, {7'd0, irq}, {7'd0, m_hdr & cfg_hdr_ie});
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  // inputs change 1 ns after a rising edge; results are read 1 ns after the next one
  task automatic send(logic [7:0] d, logic fe, logic [3:0] clrs = 4'b0000);
    @(posedge clk); #1;
    rx_valid = 1; rx_data = d; rx_ferr = fe;
    {clr_perr, clr_ferr, clr_hdr, clr_rdy} = clrs;
    @(posedge clk); #1;
    rx_valid = 0; rx_ferr = 0; rx_data = 8'h00;
    {clr_perr, clr_ferr, clr_hdr, clr_rdy} = 4'b0000;
  endtask

  task automatic clear_all();
    @(posedge clk); #1;
    {clr_perr, clr_ferr, clr_hdr, clr_rdy} = 4'b1111;
    @(posedge clk); #1;
    {clr_perr, clr_ferr, clr_hdr, clr_rdy} = 4'b0000;
  endtask

  task automatic brk();
    send(8'h00, 1'b1);
  endtask

  initial begin
    logic [7:0] keep;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    repeat (4) @(posedge clk);
    #1;
    check("R1 reset rx_dr", rx_dr, 8'h00);
    check("R1 reset flags", {3'd0, rdy, hdr, ferr, perr, irq}, 8'h00);

    cur_req = "R2";
    cfg_slave = 1;
    brk();
    check("R2 break rx_dr", rx_dr, 8'h00);
    check("R2 break rdy", {7'd0, rdy}, 8'h01);
    check("R2 break hdr", {7'd0, hdr}, 8'h01);
    check("R8 break no ferr", {7'd0, ferr}, 8'h00);
    cur_req = "R5";
    send(8'h55, 1'b0, 4'b0001);
    check("R5 synch loaded", rx_dr, 8'h55);
    check("R10 set wins over clear", {7'd0, rdy}, 8'h01);
    cur_req = "R12";
    send(8'h3C, 1'b0);
    check("R12 identifier mode0 loaded", rx_dr, 8'h3C);
    send(8'hA5, 1'b0);
    check("R12 data byte loaded", rx_dr, 8'hA5);

    cur_req = "R9";
    cfg_hdr_ie = 1;
    @(posedge clk); #1;
    check("R9 irq with hdr and enable", {7'd0, irq}, 8'h01);
    cur_req = "R10";
    send(8'h11, 1'b0, 4'b0010);
    check("R10 hdr cleared", {7'd0, hdr}, 8'h00);
    check("R9 irq drops with hdr", {7'd0, irq}, 8'h00);
    check("R10 rdy still sticky", {7'd0, rdy}, 8'h01);

    cur_req = "R4";
    cfg_auto_sync = 1;
    brk();
    clear_all();
    send(8'h55, 1'b0);
    check("R4 synch skipped rx_dr", rx_dr, 8'h00);
    check("R4 synch skipped rdy", {7'd0, rdy}, 8'h00);
    send(8'hC1, 1'b0);

    cur_req = "R3";
    cfg_auto_sync = 0; cfg_id_mode = 1;
    clear_all();
    brk();
    check("R3 break no rdy in mode1", {7'd0, rdy}, 8'h00);
    check("R3 break no hdr in mode1", {7'd0, hdr}, 8'h00);
    send(8'h55, 1'b0);
    check("R3 synch no rdy in mode1", {7'd0, rdy}, 8'h00);
    check("R3 synch rx_dr kept", rx_dr, 8'hC1);
    send(8'h3C, 1'b0);
    check("R3 identifier rx_dr", rx_dr, 8'h3C);
    check("R3 identifier hdr", {7'd0, hdr}, 8'h01);

    cur_req = "R6";
    cfg_par_en = 1;
    clear_all();
    brk(); send(8'h55, 1'b0); send(8'h00, 1'b0);
    check("R6 bad parity flagged", {7'd0, perr}, 8'h01);
    clear_all();
    send(8'h00, 1'b0);
    check("R6 data byte no perr", {7'd0, perr}, 8'h00);
    brk(); send(8'h55, 1'b0); send(8'h80, 1'b0);
    check("R6 good parity", {7'd0, perr}, 8'h00);

    cur_req = "R11";
    clear_all();
    brk(); send(8'h55, 1'b0); brk(); send(8'h55, 1'b0);
    check("R11 restart no hdr yet", {7'd0, hdr}, 8'h00);
    send(8'hC1, 1'b0);
    check("R11 identifier after restart", {7'd0, hdr}, 8'h01);
    check("R11 identifier rx_dr", rx_dr, 8'hC1);

    cur_req = "R7";
    cfg_mute = 1; cfg_id_mode = 0; cfg_par_en = 0;
    clear_all();
    keep = rx_dr;
    send(8'h77, 1'b0);
    check("R7 muted data rx_dr", rx_dr, keep);
    check("R7 muted data rdy", {7'd0, rdy}, 8'h00);
    brk();
    check("R7 muted break passes", {7'd0, rdy}, 8'h01);
    clear_all();
    send(8'h55, 1'b0); send(8'h3C, 1'b0);
    check("R7 muted identifier mode0 held", rx_dr, 8'h00);
    check("R7 muted identifier mode0 rdy", {7'd0, rdy}, 8'h00);
    cfg_id_mode = 1;
    brk(); send(8'h55, 1'b0); send(8'hC1, 1'b0);
    check("R7 muted identifier mode1 passes", rx_dr, 8'hC1);

    cur_req = "R8";
    cfg_mute = 0; cfg_id_mode = 0;
    clear_all();
    send(8'h12, 1'b1);
    check("R8 errored char sets ferr", {7'd0, ferr}, 8'h01);
    clear_all();
    cfg_slave = 0;
    send(8'h00, 1'b1);
    check("R8 non-slave zero sets ferr", {7'd0, ferr}, 8'h01);
    check("R8 non-slave zero no hdr", {7'd0, hdr}, 8'h00);
    check("R8 non-slave zero rdy", {7'd0, rdy}, 8'h01);

    repeat (3) @(posedge clk);
    #1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule